// File: doc/BRIEF.md
# Windowed Framebuffer Address Generator

This block produces write addresses for a packed display framebuffer. The framebuffer is 64 bytes wide and 80 rows tall, and each byte holds two 4-bit pixels. The block keeps a column pointer and a row pointer. Both pointers stay inside a rectangle that software loads. Each accepted data byte becomes a registered write (enable, address and data) for an external inferred RAM. The pointers then advance in one of two orders:

- **Horizontal order:** the column moves first, and the row moves when the column wraps.
- **Vertical order:** the row moves first, and the column moves when the row wraps.

Each write also raises a redraw-pending flag. The scan-out side clears this flag with a one-cycle pulse once it has refreshed the picture.

Top module: `fbwin_addr_gen`

## Requirements
- R1: After reset, no write is issued and the redraw flag is 0. The window covers columns 0..63 and rows 0..79, with both pointers at 0, so the first byte is written to address 0.
- R2: A byte strobed in cycle N gives `wr_en`=1 in cycle N+1 only. In that cycle `wr_addr` = column + row*64, taken from the pointers before the advance, and `wr_data` = the strobed byte.
- R3: In horizontal order (`vert_mode`=0), the column steps by one per byte. When the step takes it past the column end, it returns to the column start and the row steps by one. A row that passes the row end returns to the row start.
- R4: In vertical order (`vert_mode`=1), the row steps by one per byte. When the step takes it past the row end, it returns to the row start and the column steps by one. A column that passes the column end returns to the column start.
- R5: A column-window load stores the start and end, and sets the current column to the new start. The row pointer is unchanged.
- R6: A row-window load stores the start and end, and sets the current row to the new start. A loaded row value of 80 or more is reduced by 80.
- R7: If an axis has start greater than end, that axis stays at its start on every step and passes a wrap to the other axis on each byte.
- R8: Every write sets the redraw flag, one cycle after the strobe. A `redraw_clr` pulse clears the flag one cycle later. When a strobe and a clear arrive in the same cycle, the flag ends up set.
- R9: A window load in the same cycle as a strobe writes at the old pointer. The pointer of the loaded axis then equals the new start.
- R10: Changing `vert_mode` between bytes keeps both pointers. The next byte is written at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_load | input | 1 | Load the column window |
| col_first | input | 6 | Column window start |
| col_last | input | 6 | Column window end |
| row_load | input | 1 | Load the row window |
| row_first | input | 7 | Row window start (reduced modulo 80) |
| row_last | input | 7 | Row window end (reduced modulo 80) |
| vert_mode | input | 1 | 1 = vertical order, 0 = horizontal order |
| data_strobe | input | 1 | A data byte is present on `data_in` |
| data_in | input | 8 | Data byte (two 4-bit pixels) |
| redraw_clr | input | 1 | Clear pulse from the scan-out side |
| wr_en | output | 1 | Registered framebuffer write enable |
| wr_addr | output | 13 | Registered framebuffer byte address |
| wr_data | output | 8 | Registered framebuffer write data |
| redraw_pending | output | 1 | Framebuffer changed since the last clear |

## Verification
The assertions assume the inputs are sampled only on clock edges and are undefined only during reset. They also assume any byte value and any window bounds can appear, including start greater than end and row values of 80 or more. The stimulus keeps to this. It drives every input on the falling edge and draws window bounds across the full input width. It mixes in back-to-back loads and strobes, same-cycle load and strobe, and same-cycle set and clear of the redraw flag. Because the assertions rely only on cycle-level relations at the ports, they hold for any such input sequence.

// File: rtl/fbwin_pkg.sv
package fbwin_pkg;
  typedef enum logic {
    SCAN_HORIZ = 1'b0,
    SCAN_VERT  = 1'b1
  } scan_order_e;
endpackage

// File: rtl/fbwin_axis.sv
module fbwin_axis #(
  parameter int LIMIT = 64,
  parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] first_in,
  input  logic [W-1:0] last_in,
  input  logic         step,
  output logic [W-1:0] cur,
  output logic         at_wrap
);
  logic [W-1:0] first_q, last_q, first_n, last_n;
  logic [W:0]   inc;

  // Fold out-of-range load values back into 0..LIMIT-1
  generate
    if (LIMIT == (1 << W)) begin : g_pow2
      assign first_n = first_in;
      assign last_n  = last_in;
    end else begin : g_fold
      localparam logic [W-1:0] LIM_V = W'(LIMIT);
      assign first_n = (first_in >= LIM_V) ? first_in - LIM_V : first_in;
      assign last_n  = (last_in  >= LIM_V) ? last_in  - LIM_V : last_in;
    end
  endgenerate

  assign inc     = {1'b0, cur} + {{W{1'b0}}, 1'b1};
  assign at_wrap = inc > {1'b0, last_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= W'(LIMIT - 1);
      cur     <= '0;
    end else if (load) begin
      first_q <= first_n;
      last_q  <= last_n;
      cur     <= first_n;
    end else if (step) begin
      cur <= at_wrap ? first_q : inc[W-1:0];
    end
  end
endmodule

// File: rtl/fbwin_flag.sv
module fbwin_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/fbwin_addr_gen.sv
module fbwin_addr_gen
  import fbwin_pkg::*;
#(
  parameter int COLS   = 64,
  parameter int ROWS   = 80,
  parameter int DW     = 8,
  parameter int COL_W  = $clog2(COLS),
  parameter int ROW_W  = $clog2(ROWS),
  parameter int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_load,
  input  logic [COL_W-1:0]  col_first,
  input  logic [COL_W-1:0]  col_last,
  input  logic              row_load,
  input  logic [ROW_W-1:0]  row_first,
  input  logic [ROW_W-1:0]  row_last,
  input  logic              vert_mode,
  input  logic              data_strobe,
  input  logic [DW-1:0]     data_in,
  input  logic              redraw_clr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              redraw_pending
);
  localparam logic [ADDR_W-1:0] COLS_A = ADDR_W'(COLS);

  scan_order_e  order;
  logic [COL_W-1:0] col_cur;
  logic [ROW_W-1:0] row_cur;
  logic col_wrap, row_wrap, col_step, row_step;
  logic [ADDR_W-1:0] addr_n;

  assign order    = scan_order_e'(vert_mode);
  // inner axis steps every byte; outer axis steps on inner wrap
  assign col_step = data_strobe & ((order == SCAN_VERT)  ? row_wrap : 1'b1);
  assign row_step = data_strobe & ((order == SCAN_HORIZ) ? col_wrap : 1'b1);

  fbwin_axis #(.LIMIT(COLS), .W(COL_W)) u_col (
    .clk(clk), .rst(rst), .load(col_load), .first_in(col_first),
    .last_in(col_last), .step(col_step), .cur(col_cur), .at_wrap(col_wrap)
  );

  fbwin_axis #(.LIMIT(ROWS), .W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .load(row_load), .first_in(row_first),
    .last_in(row_last), .step(row_step), .cur(row_cur), .at_wrap(row_wrap)
  );

  assign addr_n = ADDR_W'(row_cur) * COLS_A + ADDR_W'(col_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= data_strobe;
      if (data_strobe) begin
        wr_addr <= addr_n;
        wr_data <= data_in;
      end
    end
  end

  fbwin_flag u_redraw (
    .clk(clk), .rst(rst), .set(data_strobe), .clr(redraw_clr),
    .q(redraw_pending)
  );
endmodule

// File: rtl/fbwin_addr_gen_chk.sv
module fbwin_addr_gen_chk #(
  parameter int COLS   = 64,
  parameter int ROWS   = 80,
  parameter int DW     = 8,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              data_strobe,
  input logic [DW-1:0]     data_in,
  input logic              redraw_clr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              redraw_pending
);
  localparam int TOTAL = COLS * ROWS;

  // R2
  strobe_to_write_chk: assert property (@(posedge clk) disable iff (rst)
    data_strobe |=> wr_en);
  // R2
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (rst)
    !data_strobe |=> !wr_en);
  // R2
  write_data_chk: assert property (@(posedge clk) disable iff (rst)
    data_strobe |=> (wr_data == $past(data_in)));
  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < TOTAL));
  // R8
  redraw_set_chk: assert property (@(posedge clk) disable iff (rst)
    data_strobe |=> redraw_pending);
  // R8
  redraw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (redraw_clr && !data_strobe) |=> !redraw_pending);
  // R8
  redraw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!redraw_clr && !data_strobe) |=> $stable(redraw_pending));
endmodule

bind fbwin_addr_gen fbwin_addr_gen_chk #(
  .COLS(COLS), .ROWS(ROWS), .DW(DW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .data_strobe(data_strobe), .data_in(data_in),
  .redraw_clr(redraw_clr), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .redraw_pending(redraw_pending)
);

// File: tb/fbwin_addr_gen_tb.sv
module fbwin_addr_gen_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic col_load = 0, row_load = 0, vert_mode = 0, data_strobe = 0, redraw_clr = 0;
  logic [5:0] col_first = 0, col_last = 0;
  logic [6:0] row_first = 0, row_last = 0;
  logic [7:0] data_in = 0;
  logic wr_en, redraw_pending;
  logic [12:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_col, m_row, m_cs, m_ce, m_rs, m_re;
  bit m_vert;

  always #4 clk = ~clk;

  fbwin_addr_gen u_dut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fold_row(int v);
    return (v >= 80) ? v - 80 : v;
  endfunction

  function automatic int exp_addr();
    return m_col + m_row * 64;
  endfunction

  // Requirement-level model of the pointer walk (R3, R4)
  task automatic model_advance();
    if (m_vert) begin
      m_row++;
      if (m_row > m_re) begin m_row = m_rs; m_col++; end
      if (m_col > m_ce) m_col = m_cs;
    end else begin
      m_col++;
      if (m_col > m_ce) begin m_row++; m_col = m_cs; end
      if (m_row > m_re) m_row = m_rs;
    end
  endtask

  task automatic put_byte(string req, logic [7:0] b);
    int ea;
    ea = exp_addr();
    @(negedge clk);
    data_strobe = 1; data_in = b;
    @(negedge clk);
    data_strobe = 0;
    chk({req, " wr_en"}, int'(wr_en), 1);
    chk({req, " addr"}, int'(wr_addr), ea);
    chk({req, " data"}, int'(wr_data), int'(b));
    model_advance();
  endtask

  task automatic load_cols(int s, int e);
    @(negedge clk);
    col_load = 1; col_first = 6'(s); col_last = 6'(e);
    @(negedge clk);
    col_load = 0;
    m_cs = s % 64; m_ce = e % 64; m_col = m_cs;
  endtask

  task automatic load_rows(int s, int e);
    @(negedge clk);
    row_load = 1; row_first = 7'(s); row_last = 7'(e);
    @(negedge clk);
    row_load = 0;
    m_rs = fold_row(s); m_re = fold_row(e); m_row = m_rs;
  endtask

  task automatic set_mode(bit v);
    @(negedge clk);
    vert_mode = v; m_vert = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_col = 0; m_row = 0; m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79; m_vert = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 redraw", int'(redraw_pending), 0);
    put_byte("R1 first", 8'hA5);
    // R8 set, clear, and set-wins
    chk("R8 set", int'(redraw_pending), 1);
    @(negedge clk); redraw_clr = 1;
    @(negedge clk); redraw_clr = 0;
    chk("R8 clear", int'(redraw_pending), 0);
    chk("R2 single pulse", int'(wr_en), 0);
    @(negedge clk); redraw_clr = 1; data_strobe = 1; data_in = 8'h3C;
    @(negedge clk); redraw_clr = 0; data_strobe = 0;
    chk("R8 set wins", int'(redraw_pending), 1);
    chk("R2 addr", int'(wr_addr), exp_addr());
    model_advance();
    // R3 horizontal wrap in small window
    load_cols(62, 63);
    load_rows(78, 79);
    for (int i = 0; i < 6; i++) put_byte("R3 horiz", 8'(i));
    // R4 vertical wrap
    set_mode(1);
    load_cols(5, 7);
    load_rows(10, 11);
    for (int i = 0; i < 8; i++) put_byte("R4 vert", 8'(i + 16));
    // R5 column load leaves row alone
    put_byte("R5 pre", 8'h11);
    load_cols(20, 30);
    put_byte("R5 col load", 8'h22);
    // R6 row fold of out-of-range values
    load_rows(100, 127);
    chk("R6 fold start", m_rs, 20);
    put_byte("R6 folded", 8'h33);
    // R7 start greater than end
    set_mode(0);
    load_cols(40, 10);
    load_rows(0, 79);
    for (int i = 0; i < 4; i++) put_byte("R7 col stuck", 8'(i));
    set_mode(1);
    load_rows(50, 3);
    for (int i = 0; i < 4; i++) put_byte("R7 row stuck", 8'(i));
    // R9 load and strobe in the same cycle
    set_mode(0);
    load_cols(0, 63);
    begin
      int ea;
      ea = exp_addr();
      @(negedge clk);
      col_load = 1; col_first = 6'd9; col_last = 6'd12;
      data_strobe = 1; data_in = 8'h77;
      @(negedge clk);
      col_load = 0; data_strobe = 0;
      chk("R9 old pointer", int'(wr_addr), ea);
      m_cs = 9; m_ce = 12; m_col = 9;
      put_byte("R9 new start", 8'h78);
    end
    // R10 mode flip mid-stream plus random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) load_cols(int'($urandom_range(0, 63)), int'($urandom_range(0, 63)));
      else if (op == 1) load_rows(int'($urandom_range(0, 127)), int'($urandom_range(0, 127)));
      else if (op == 2) set_mode(1'($urandom_range(0, 1)));
      else put_byte("R10 random", 8'($urandom_range(0, 255)));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule